// File: doc/BRIEF.md
# Instruction Fetch and Effective-Address Front End

This block is the front of a five-stage, 32-bit processor pipeline whose instructions name one register and one memory address. It holds the first two stages. The fetch stage reads one instruction word per cycle from a word-addressed memory read port. It then hands the word and the address it came from to the address stage.

The address stage looks at the instruction's index field. It reads a register-file port only when the index names a real base register. It adds the sign-extended displacement to that base, to zero, or to the instruction's own fetch address. The result goes to the next stage, together with the opcode and the destination register number.

The memory and the register file are outside the block. Each is reached through a port with a request strobe that says whether the port is in use this cycle. Both stages carry a valid bit, so the empty slots that follow a reset travel down the pipe as no-operations.

Top module: `fe_addrgen`

## Requirements
- R1: The instruction word is split into four fields: opcode in bits 31:24, destination register in bits 23:20, index in bits 19:16, and a 16-bit displacement in bits 15:0.
- R2: `imem_addr` holds the fetch pc. It is 0 in the first cycle after reset and grows by one word every cycle. `imem_req` is high in every cycle.
- R3: A word returned for fetch address a shows up at the stage outputs two clock edges later. At that point `ag_valid` is high, `ag_opcode` carries bits 31:24 and `ag_rdst` carries bits 23:20.
- R4: When the index is 0, the effective address is the sign-extended displacement, and `rf_req` is low while that instruction sits in the address stage.
- R5: When the index is 15, the effective address is the instruction's fetch address plus the sign-extended displacement, and `rf_req` is low.
- R6: For any index from 1 to 14, `rf_sel` carries the index and `rf_req` is high one cycle after the fetch. The effective address is the `rf_rdata` returned in that same cycle plus the sign-extended displacement.
- R7: The displacement's bit 15 is copied into bits 31:16 before the addition, and the addition wraps modulo 2^32.
- R8: A synchronous reset sets pc to 0 and clears both valid bits. `ag_valid` stays low for the first two cycles after reset, and `rf_req` is low for the first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for pc and both stage registers |
| rst | input | 1 | Synchronous reset, active high |
| imem_req | output | 1 | Memory read port in use |
| imem_addr | output | 32 | Word address being fetched (pc) |
| imem_rdata | input | 32 | Instruction word returned in the same cycle |
| rf_req | output | 1 | Register read port in use |
| rf_sel | output | 4 | Register number presented to the read port |
| rf_rdata | input | 32 | Register value returned in the same cycle |
| ag_valid | output | 1 | Address-stage output holds an instruction |
| ag_opcode | output | 8 | Opcode of that instruction |
| ag_rdst | output | 4 | Register field of that instruction |
| ag_addr | output | 32 | Computed effective address |

## Verification
The bench builds the block with its default widths: a 32-bit word, 4-bit register numbers and a 16-bit displacement. With these widths the two reserved index codes and the sign bit of the displacement are all reachable.

The bench runs about 300 cycles, so its 256-word program image wraps. Random words cover every index code, and directed words push a PC-relative address below zero and a register base past 2^32. A reset in mid-run shows that the pipe drains back to bubbles and that pc restarts at zero.

// File: rtl/fe_addrgen.sv
module fe_addrgen #(
  parameter int XLEN   = 32,
  parameter int OPC_W  = 8,
  parameter int RSEL_W = 4,
  parameter int DISP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  output logic              imem_req,
  output logic [XLEN-1:0]   imem_addr,
  input  logic [XLEN-1:0]   imem_rdata,
  output logic              rf_req,
  output logic [RSEL_W-1:0] rf_sel,
  input  logic [XLEN-1:0]   rf_rdata,
  output logic              ag_valid,
  output logic [OPC_W-1:0]  ag_opcode,
  output logic [RSEL_W-1:0] ag_rdst,
  output logic [XLEN-1:0]   ag_addr
);
  localparam int X_LO   = DISP_W;
  localparam int R_LO   = X_LO + RSEL_W;
  localparam int OPC_LO = R_LO + RSEL_W;
  localparam logic [RSEL_W-1:0] X_NONE = '0;
  localparam logic [RSEL_W-1:0] X_PC   = '1;

  logic [XLEN-1:0] pc_q;
  logic            f_valid;
  logic [XLEN-1:0] f_ir;
  logic [XLEN-1:0] f_pc;

  assign imem_req  = 1'b1;
  assign imem_addr = pc_q;

  logic [RSEL_W-1:0] f_x;
  logic [DISP_W-1:0] f_disp;
  logic [XLEN-1:0]   disp_ext;
  logic [XLEN-1:0]   base;

  assign f_x      = f_ir[X_LO +: RSEL_W];
  assign f_disp   = f_ir[0 +: DISP_W];
  assign disp_ext = {{(XLEN-DISP_W){f_disp[DISP_W-1]}}, f_disp};
  assign rf_sel   = f_x;
  assign rf_req   = f_valid && (f_x != X_NONE) && (f_x != X_PC);

  always_comb begin
    if (f_x == X_NONE)    base = '0;
    else if (f_x == X_PC) base = f_pc;
    else                  base = rf_rdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q     <= '0;
      f_valid  <= 1'b0;
      ag_valid <= 1'b0;
    end else begin
      pc_q     <= pc_q + 1'b1;
      f_valid  <= 1'b1;
      ag_valid <= f_valid;
    end
    f_ir      <= imem_rdata;
    f_pc      <= pc_q;
    ag_opcode <= f_ir[OPC_LO +: OPC_W];
    ag_rdst   <= f_ir[R_LO +: RSEL_W];
    ag_addr   <= base + disp_ext;
  end

  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    f_valid |-> imem_addr == f_pc + 1'b1); // R2
  AST_IR_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (f_ir == $past(imem_rdata)) && (f_pc == $past(imem_addr))); // R3
  AST_RF_IDLE_RESERVED: assert property (@(posedge clk) disable iff (rst)
    rf_req |-> f_valid && rf_sel != X_NONE && rf_sel != X_PC); // R5
  AST_ZERO_BASE: assert property (@(posedge clk) disable iff (rst)
    (f_valid && f_x == X_NONE) |=> ag_addr == $past(disp_ext)); // R4
  AST_BUBBLE_FLOW: assert property (@(posedge clk) disable iff (rst)
    !f_valid |=> !ag_valid); // R8
endmodule

// File: tb/fe_addrgen_bench.sv
module fe_addrgen_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        imem_req;
  logic [31:0] imem_addr;
  logic [31:0] imem_rdata;
  logic        rf_req;
  logic [3:0]  rf_sel;
  logic [31:0] rf_rdata;
  logic        ag_valid;
  logic [7:0]  ag_opcode;
  logic [3:0]  ag_rdst;
  logic [31:0] ag_addr;

  logic [31:0] mem [256];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] regval(input logic [3:0] s);
    if (s == 4'd7) return 32'hFFFF_FFF0;
    return ({28'd0, s} * 32'h0123_4567) ^ 32'hA5A5_0000;
  endfunction

  function automatic logic [31:0] exp_ea(input logic [31:0] w, input logic [31:0] pc);
    logic [31:0] d;
    d = {{16{w[15]}}, w[15:0]};
    if (w[19:16] == 4'd0)  return d;
    if (w[19:16] == 4'd15) return pc + d;
    return regval(w[19:16]) + d;
  endfunction

  assign imem_rdata = mem[imem_addr[7:0]];
  assign rf_rdata   = rf_req ? regval(rf_sel) : 32'h5A5A_C3C3;

  fe_addrgen u_fe_addrgen (
    .clk(clk), .rst(rst),
    .imem_req(imem_req), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .rf_req(rf_req), .rf_sel(rf_sel), .rf_rdata(rf_rdata),
    .ag_valid(ag_valid), .ag_opcode(ag_opcode), .ag_rdst(ag_rdst), .ag_addr(ag_addr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_cycle(input int n);
    logic [31:0] w1, w2;
    logic        req1;
    chk(imem_addr == n, "R2 imem_addr", imem_addr, n);
    chk(imem_req == 1'b1, "R2 imem_req", {31'd0, imem_req}, 1);
    if (n == 0) begin
      chk(rf_req == 1'b0, "R8 rf_req after reset", {31'd0, rf_req}, 0);
    end else begin
      w1 = mem[(n-1) & 255];
      req1 = (w1[19:16] != 4'd0) && (w1[19:16] != 4'd15);
      chk(rf_req == req1, req1 ? "R6 rf_req" : "R4/R5 rf_req idle", {31'd0, rf_req}, {31'd0, req1});
      if (req1) chk(rf_sel == w1[19:16], "R6 rf_sel", {28'd0, rf_sel}, {28'd0, w1[19:16]});
    end
    if (n < 2) begin
      chk(ag_valid == 1'b0, "R8 ag_valid bubble", {31'd0, ag_valid}, 0);
    end else begin
      w2 = mem[(n-2) & 255];
      chk(ag_valid == 1'b1, "R3 ag_valid", {31'd0, ag_valid}, 1);
      chk(ag_opcode == w2[31:24], "R1 opcode", {24'd0, ag_opcode}, {24'd0, w2[31:24]});
      chk(ag_rdst == w2[23:20], "R1 rdst", {28'd0, ag_rdst}, {28'd0, w2[23:20]});
      chk(ag_addr == exp_ea(w2, n-2), "R7 effective address", ag_addr, exp_ea(w2, n-2));
    end
  endtask

  task automatic run(input int cycles);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(ag_valid == 1'b0, "R8 ag_valid in reset", {31'd0, ag_valid}, 0);
    chk(imem_addr == 0, "R8 pc in reset", imem_addr, 0);
    rst = 1'b0;
    check_cycle(0);
    for (int n = 1; n <= cycles; n++) begin
      @(negedge clk);
      check_cycle(n);
    end
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    for (int i = 0; i < 256; i++) mem[i] = $urandom;
    mem[2] = 32'h11_3_0_FFFE; // R4 index 0, negative displacement
    mem[3] = 32'h22_5_F_0010; // R5 pc-relative forward
    mem[4] = 32'h33_6_F_8000; // R7 pc-relative wraps below zero
    mem[5] = 32'h44_7_7_0010; // R7 register base wraps past 2^32
    mem[6] = 32'h55_8_1_7FFF; // R6 lowest general index
    mem[7] = 32'h66_9_E_8001; // R6 highest general index
    mem[8] = 32'h77_A_0_7FFF; // R4 largest positive displacement
    mem[9] = 32'h88_B_F_0000; // R5 zero displacement
    @(negedge clk);
    run(300);
    run(40);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule